// File: doc/BRIEF.md
# Instruction Prefetch Queue with Breakpoint Tagging

This block sits between the bus fetch path and the execute stage of a processor core. Each bus read that delivers instruction words also samples the external breakpoint input on the same clock edge. The sampled value is stored as a tag beside every instruction word that came from that read. When the execute stage takes a tagged word from the head of the queue, the block raises a one-cycle breakpoint-acknowledge request that the exception logic acts on.

The queue holds four 16-bit instruction words. A 16-bit bus delivers one word per fetch, taken from the low half of the data input. A 32-bit bus delivers two words per fetch, and both carry the same tag. That shared tag stands for a single breakpoint request, so the trap fires once: after the first word is consumed and before the second word executes. A pipeline flush empties the queue and drops every tag in one cycle. A breakpoint that lasted only one bus cycle is therefore lost if a flush comes first. A breakpoint that is held is sampled again by the next fetch after the flush.

Top module: `pfq_bkpt_queue`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, head_valid_o, head_instr_o, head_tag_o, bkpt_ack_o and full_o are all 0.
- R2: With bus_wide_i=0, an accepted fetch appends one word, fetch_data_i[15:0], whose tag is the value of bkpt_i on the same clock edge. Words leave in fetch order.
- R3: With bus_wide_i=1, an accepted fetch appends two words: fetch_data_i[31:16] first, then fetch_data_i[15:0]. Both carry the bkpt_i value sampled on that edge.
- R4: full_o is 1 when the queue holds 4 words (narrow) or more than 2 words (wide). While full_o is 1, fetch_valid_i is ignored and the queue contents do not change.
- R5: head_valid_o is 1 whenever the queue is not empty. head_instr_o shows the oldest word, or 0 when the queue is empty. consume_i removes that word when head_valid_o is 1.
- R6: Consuming a head word whose tag is 1 drives bkpt_ack_o to 1 for exactly the following cycle. Consuming an untagged word leaves bkpt_ack_o at 0.
- R7: Consuming the tagged first word of a wide fetch clears the tag of its partner word. This gives one acknowledge, issued between the two words.
- R8: flush_i empties the queue and clears all tags in one cycle. A fetch or consume in that cycle is ignored, and no acknowledge results from it.
- R9: After a flush, a fetch taken while bkpt_i is still held high is tagged again, so the breakpoint is still detected.
- R10: A fetch and a consume in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Bus read data valid strobe |
| fetch_data_i | input | 32 | Bus read data |
| bkpt_i | input | 1 | External breakpoint request, sampled with the data |
| bus_wide_i | input | 1 | 1: 32-bit bus (two words per fetch), 0: 16-bit bus |
| flush_i | input | 1 | Pipeline flush |
| consume_i | input | 1 | Execute stage takes the head word |
| head_valid_o | output | 1 | Queue not empty |
| head_instr_o | output | 16 | Oldest instruction word |
| head_tag_o | output | 1 | Breakpoint tag of the head word |
| bkpt_ack_o | output | 1 | Breakpoint-acknowledge request, one cycle |
| full_o | output | 1 | Queue cannot accept a fetch at the current width |

## Verification
The assertions assume that bus_wide_i changes only while the queue is empty, because the full threshold and the pair bookkeeping depend on it. The stimulus switches width only right after a flush or after the queue has been drained. The assertions also assume that consume_i may arrive with the queue empty or together with flush_i. The stimulus does both on purpose, and the checks confirm that these cases change nothing. Fetches presented while full_o is high are expected to be dropped rather than stalled, and the stimulus relies on this when it drives full-queue fetches with the breakpoint high.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned BUS_W   = 2 * INSTR_W;

  typedef struct packed {
    logic [INSTR_W-1:0] instr;
    logic               tag;
    logic               pair;  // first half of a wide fetch
  } pfq_entry_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fetch_valid_i,
  input  logic             wide_i,
  input  logic             flush_i,
  input  logic             consume_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, add_n;

  assign full_o = wide_i ? (cnt_q > CNT_W'(DEPTH - 2)) : (cnt_q == CNT_W'(DEPTH));
  assign push_o = fetch_valid_i & ~full_o & ~flush_i;
  assign pop_o  = consume_i & (cnt_q != '0) & ~flush_i;
  assign add_n  = push_o ? (wide_i ? CNT_W'(2) : CNT_W'(1)) : '0;

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_q + add_n - CNT_W'(pop_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R4
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !consume_i && !flush_i) |=> (cnt_q == $past(cnt_q)));

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));

  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && cnt_q == '0 && !fetch_valid_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wide_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [BUS_W-1:0] fetch_data_i,
  input  logic             bkpt_i,
  output pfq_entry_t       head_o
);
  pfq_entry_t q [DEPTH+1];   // slot DEPTH stays zero, feeds the shift
  pfq_entry_t nxt [DEPTH];
  pfq_entry_t hi_e, lo_e;
  logic [CNT_W-1:0] base, base_p1;
  logic [DEPTH-1:0] tag_vec;

  assign hi_e    = '{instr: fetch_data_i[BUS_W-1:INSTR_W], tag: bkpt_i, pair: 1'b1};
  assign lo_e    = '{instr: fetch_data_i[INSTR_W-1:0],     tag: bkpt_i, pair: 1'b0};
  assign base    = cnt_i - CNT_W'(pop_i);
  assign base_p1 = base + CNT_W'(1);
  assign q[DEPTH] = '0;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = pop_i ? q[i+1] : q[i];
      // one request covers both halves: drop the partner's tag
      if (i == 0 && pop_i && q[0].tag && q[0].pair) nxt[i].tag = 1'b0;
      if (push_i && base == CNT_W'(i)) nxt[i] = wide_i ? hi_e : lo_e;
      if (push_i && wide_i && base_p1 == CNT_W'(i)) nxt[i] = lo_e;
      if (flush_i) nxt[i] = '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= '0;
      else         q[g] <= nxt[g];
    end
    assign tag_vec[g] = q[g].tag;
  end

  assign head_o = q[0];

  // R7
  pair_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && q[0].tag && q[0].pair) |=> !q[0].tag);

  // R8
  flush_tags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tag_vec == '0));
endmodule

// File: rtl/pfq_ack.sv
module pfq_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pop_i,
  input  logic head_tag_i,
  output logic ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= pop_i & head_tag_i;
  end
endmodule

// File: rtl/pfq_bkpt_queue.sv
module pfq_bkpt_queue
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_valid_i,
  input  logic [BUS_W-1:0]   fetch_data_i,
  input  logic               bkpt_i,
  input  logic               bus_wide_i,
  input  logic               flush_i,
  input  logic               consume_i,
  output logic               head_valid_o,
  output logic [INSTR_W-1:0] head_instr_o,
  output logic               head_tag_o,
  output logic               bkpt_ack_o,
  output logic               full_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             push, pop;
  logic [CNT_W-1:0] cnt;
  pfq_entry_t       head;

  pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .fetch_valid_i,
    .wide_i   (bus_wide_i),
    .flush_i, .consume_i,
    .push_o   (push),
    .pop_o    (pop),
    .cnt_o    (cnt),
    .full_o
  );

  pfq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i   (push),
    .pop_i    (pop),
    .wide_i   (bus_wide_i),
    .flush_i,
    .cnt_i    (cnt),
    .fetch_data_i, .bkpt_i,
    .head_o   (head)
  );

  assign head_valid_o = (cnt != '0);
  assign head_instr_o = head_valid_o ? head.instr : '0;
  assign head_tag_o   = head_valid_o & head.tag;

  pfq_ack u_ack (
    .clk_i, .rst_ni,
    .pop_i      (pop),
    .head_tag_i (head_tag_o),
    .ack_o      (bkpt_ack_o)
  );

  // R6
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_ack_o |-> $past(consume_i && head_tag_o && !flush_i));

  // R8
  flush_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !bkpt_ack_o);
endmodule

// File: tb/pfq_bkpt_queue_bench.sv
module pfq_bkpt_queue_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_data_i = '0;
  logic        bkpt_i = 1'b0;
  logic        bus_wide_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        consume_i = 1'b0;
  logic        head_valid_o;
  logic [15:0] head_instr_o;
  logic        head_tag_o;
  logic        bkpt_ack_o;
  logic        full_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pfq_bkpt_queue u_pfq_bkpt_queue (
    .clk_i(clk), .rst_ni, .fetch_valid_i, .fetch_data_i, .bkpt_i,
    .bus_wide_i, .flush_i, .consume_i,
    .head_valid_o, .head_instr_o, .head_tag_o, .bkpt_ack_o, .full_o
  );

  typedef struct packed {
    logic fv; logic [31:0] d; logic bk; logic wd; logic fl; logic cs;
    logic [3:0] rq;
    logic hv; logic [15:0] ins; logic tg; logic ak; logic fu;
  } vec_t;

  localparam int NV = 24;
  // expected = outputs after the edge that takes the row's inputs
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1111, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 16'h1111, 1'b0, 1'b0, 1'b0}, // R2
    '{1'b1, 32'h0000_2222, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 16'h1111, 1'b0, 1'b0, 1'b0}, // R2
    '{1'b1, 32'h0000_3333, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10, 1'b1, 16'h2222, 1'b1, 1'b0, 1'b0}, // R10
    '{1'b1, 32'h0000_4444, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 16'h2222, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b1, 32'h0000_5555, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4,  1'b1, 16'h2222, 1'b1, 1'b0, 1'b1}, // R4
    '{1'b1, 32'h0000_6666, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4,  1'b1, 16'h2222, 1'b1, 1'b0, 1'b1}, // R4
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  1'b1, 16'h3333, 1'b0, 1'b1, 1'b0}, // R6
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b1, 16'h4444, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b1, 16'h5555, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R5
    '{1'b1, 32'hAAAA_BBBB, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  1'b1, 16'hAAAA, 1'b1, 1'b0, 1'b0}, // R3
    '{1'b1, 32'hCCCC_DDDD, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4,  1'b1, 16'hAAAA, 1'b1, 1'b0, 1'b1}, // R4
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  1'b1, 16'hBBBB, 1'b0, 1'b1, 1'b1}, // R7
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  1'b1, 16'hCCCC, 1'b0, 1'b0, 1'b0}, // R7
    '{1'b1, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b1, 4'd10, 1'b1, 16'hDDDD, 1'b0, 1'b0, 1'b1}, // R10
    '{1'b1, 32'h9999_8888, 1'b1, 1'b1, 1'b1, 1'b1, 4'd8,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R8
    '{1'b1, 32'hEEEE_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9,  1'b1, 16'hEEEE, 1'b1, 1'b0, 1'b0}, // R9
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  1'b1, 16'hFFFF, 1'b0, 1'b1, 1'b0}, // R7
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 4'd7,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R7
    '{1'b1, 32'h0000_7777, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 16'h7777, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b1, 32'h0000_8888, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  1'b1, 16'h7777, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  1'b1, 16'h8888, 1'b1, 1'b1, 1'b0}, // R6
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  1'b0, 16'h0000, 1'b0, 1'b1, 1'b0}, // R6
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 4'd6,  1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}  // R6
  };

  task automatic chk(input int rq, input string what, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [19:0] outs();
    return {head_valid_o, head_instr_o, head_tag_o, bkpt_ack_o, full_o};
  endfunction

  task automatic step(input logic fv, input logic [31:0] d, input logic bk,
                      input logic wd, input logic fl, input logic cs);
    fetch_valid_i = fv; fetch_data_i = d; bkpt_i = bk;
    bus_wide_i = wd; flush_i = fl; consume_i = cs;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(1, "in reset", outs(), 20'h0);          // R1
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, "after release", outs(), 20'h0);     // R1

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].fv, VECS[i].d, VECS[i].bk, VECS[i].wd, VECS[i].fl, VECS[i].cs);
      chk(int'(VECS[i].rq), $sformatf("vector %0d", i), outs(),
          {VECS[i].hv, VECS[i].ins, VECS[i].tg, VECS[i].ak, VECS[i].fu});
    end

    // R4: narrow fill to four words, then flush clears full (R8)
    step(1'b1, 32'h0000_0A01, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0000_0A02, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0000_0A03, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(4, "three narrow words not full", outs(), {1'b1, 16'h0A01, 3'b000});
    step(1'b1, 32'h0000_0A04, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(4, "four narrow words full", outs(), {1'b1, 16'h0A01, 3'b001});
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(8, "flush of full queue", outs(), 20'h0);

    // R1: asynchronous reset while holding a tagged word
    step(1'b1, 32'h0000_0B01, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(2, "tagged narrow word", outs(), {1'b1, 16'h0B01, 3'b100});
    #3 rst_ni = 1'b0;
    #2 chk(1, "async reset clears outputs", outs(), 20'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(5, "consume on empty after reset", outs(), 20'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule